// File: doc/BRIEF.md
# Control-Word Stack Machine Core

This block is a 16-bit stack machine core that runs one 8-bit opcode per clock cycle with no microcode. Each bit, or pair of bits, of the opcode drives one piece of hardware directly. The top three bits pick one of two stack pointers and say whether and in which direction it steps. The next bit gates the top-of-stack (TOS) accumulator onto its consumers. The remaining two bit pairs feed two separate 2-to-4 decodes: one chooses what happens on the stack bus and the other chooses what drives the TOS bus. The core has a data pointer (D), a return pointer (R), a TOS register, a program counter and a one-bit cycle-parity flag. TOS is loaded from the TOS bus only at the end of every second cycle, so an operation that changes TOS takes an opcode pair.

The program counter addresses both the opcode memory and a 16-bit constant memory (ROM) at the same location. There is one stack memory port, addressed by whichever pointer is selected, and one RAM port, addressed by TOS. All three memories are outside the core. They are read combinationally in the same cycle and written at the clock edge that ends the cycle. These ports carry no valid/ready handshake and the core never stalls, so there is no back-pressure: every memory must answer within the cycle. Reset is active-low and asynchronous.

Top module: `ctlword_stack_core`

## Requirements
- R1: While reset is asserted, the program counter, both stack pointers and TOS read zero. The parity flag also clears, so the first cycle after reset does not load TOS.
- R2: Opcode bit 7 selects the pointer: 0 selects D and 1 selects R. `stk_addr` shows the selected pointer's value before any step in that cycle.
- R3: Opcode bit 5 = 1 steps the selected pointer: +1 when bit 6 is 1 and −1 when bit 6 is 0, wrapping modulo 256. Bit 5 = 0 holds both pointers, and the unselected pointer never changes.
- R4: Opcode bit 4 is an active-low TOS enable. When it is 1, the ALU operand taken from TOS, the RAM address and the value TOS places on the stack bus are all zero.
- R5: Stack-bus code 00 (bits 3:2) puts the stack memory read data on the stack bus. It writes neither the stack nor RAM.
- R6: Stack-bus code 01 writes the gated TOS value into the stack at `stk_addr`.
- R7: Stack-bus code 10 writes the stack read data into RAM at the address given by the gated TOS value. It does not write the stack.
- R8: Stack-bus code 11 writes the RAM read data into the stack at `stk_addr`.
- R9: TOS-bus code (bits 1:0) 00 selects the ROM word at the program counter, 01 selects NAND of the gated TOS and the stack bus, 10 selects their sum modulo 2^16, and 11 selects the current TOS.
- R10: TOS takes the TOS-bus value only at the end of the 2nd, 4th, 6th … cycle after reset. In all other cycles it holds.
- R11: When the TOS-bus code is 11 and TOS is zero, the program counter loads the low 8 bits of the ROM word at the current address. Otherwise it increments and wraps modulo 256.
- R12: The two-cycle pair 0x64, 0x10 pushes a literal. The old TOS is written at D, D advances by one, and TOS ends up holding the ROM word fetched in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_addr | output | 8 | Program counter; address for opcode and ROM |
| op_data | input | 8 | Opcode at `op_addr` |
| rom_data | input | 16 | ROM word at `op_addr` |
| stk_addr | output | 8 | Stack memory address (selected pointer) |
| stk_rdata | input | 16 | Stack memory read data |
| stk_we | output | 1 | Stack memory write enable |
| stk_wdata | output | 16 | Stack memory write data (stack bus) |
| ram_addr | output | 16 | RAM address (gated TOS) |
| ram_rdata | input | 16 | RAM read data |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 16 | RAM write data (stack bus) |
| tos | output | 16 | Current top-of-stack value |
| d_ptr | output | 8 | Data-stack pointer |
| r_ptr | output | 8 | Return-stack pointer |

## Verification
A hand-built program starts the run. It pushes literals, adds and NANDs against stack operands, moves data between RAM and the stack, steps R, wraps D downwards through zero, and takes and skips a jump. This shows whether each decode value reaches the right bus, and whether addresses are taken before or after the pointer steps. The rest of the opcode memory is filled with a computed spread of all 256 codes. Those codes run in both cycle parities, which exposes any TOS load on the wrong cycle and any mix-up between the gated and raw TOS. Program counter wrap-around re-runs the program from different state, and a mid-run reset checks that everything returns to zero.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int OPW = 8;

  typedef enum logic [1:0] {
    SB_OPERAND  = 2'd0,
    SB_PUSH_TOS = 2'd1,
    SB_TO_RAM   = 2'd2,
    SB_FROM_RAM = 2'd3
  } sbus_e;

  typedef enum logic [1:0] {
    TB_ROM  = 2'd0,
    TB_NAND = 2'd1,
    TB_ADD  = 2'd2,
    TB_JZ   = 2'd3
  } tbus_e;

  // field order follows opcode bit order, MSB first
  typedef struct packed {
    logic  use_r;
    logic  step_up;
    logic  step_en;
    logic  tos_off;
    sbus_e sb;
    tbus_e tb;
  } ctl_t;
endpackage

// File: rtl/scm_decode.sv
module scm_decode
  import scm_pkg::*;
(
  input  logic [OPW-1:0] op,
  output ctl_t           ctl,
  output logic [3:0]     sb_oh,
  output logic [3:0]     tb_oh,
  output logic           stk_we,
  output logic           ram_we
);
  assign ctl = ctl_t'(op);

  // two independent 2-to-4 decodes
  generate
    for (genvar k = 0; k < 4; k++) begin : g_dec
      assign sb_oh[k] = (op[3:2] == 2'(k));
      assign tb_oh[k] = (op[1:0] == 2'(k));
    end
  endgenerate

  assign stk_we = sb_oh[SB_PUSH_TOS] | sb_oh[SB_FROM_RAM];
  assign ram_we = sb_oh[SB_TO_RAM];
endmodule

// File: rtl/scm_ptrs.sv
module scm_ptrs #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_r,
  input  logic          step_en,
  input  logic          step_up,
  output logic [PW-1:0] d_ptr,
  output logic [PW-1:0] r_ptr,
  output logic [PW-1:0] cur
);
  localparam logic [PW-1:0] ONE = PW'(1);

  generate
    for (genvar k = 0; k < 2; k++) begin : g_ptr
      logic [PW-1:0] q;
      logic          mine;
      assign mine = (use_r == 1'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (step_en && mine)
          q <= step_up ? q + ONE : q - ONE;
      end
    end
  endgenerate

  assign d_ptr = g_ptr[0].q;
  assign r_ptr = g_ptr[1].q;
  assign cur   = use_r ? r_ptr : d_ptr;

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> (d_ptr == $past(d_ptr)) && (r_ptr == $past(r_ptr))); // R3
  AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    use_r |=> d_ptr == $past(d_ptr)); // R3
  AST_D_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !use_r && step_up) |=> d_ptr == PW'($past(d_ptr) + ONE)); // R3
endmodule

// File: rtl/scm_datapath.sv
module scm_datapath #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] tos_q,
  input  logic          tos_off,
  input  logic [3:0]    sb_oh,
  input  logic [3:0]    tb_oh,
  input  logic [DW-1:0] stk_rdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic [DW-1:0] rom_data,
  output logic [DW-1:0] tos_drv,
  output logic [DW-1:0] stk_bus,
  output logic [DW-1:0] tos_bus
);
  logic [DW-1:0] sb_src [4];
  logic [DW-1:0] tb_src [4];
  logic [DW-1:0] nand_r, add_r;

  assign tos_drv = tos_off ? '0 : tos_q;
  assign nand_r  = ~(tos_drv & stk_bus);
  assign add_r   = tos_drv + stk_bus;

  assign sb_src[0] = stk_rdata;
  assign sb_src[1] = tos_drv;
  assign sb_src[2] = stk_rdata;
  assign sb_src[3] = ram_rdata;

  assign tb_src[0] = rom_data;
  assign tb_src[1] = nand_r;
  assign tb_src[2] = add_r;
  assign tb_src[3] = tos_q;

  // AND-OR selection straight from the one-hot decodes
  always_comb begin
    stk_bus = '0;
    tos_bus = '0;
    for (int k = 0; k < 4; k++) begin
      stk_bus = stk_bus | (sb_src[k] & {DW{sb_oh[k]}});
      tos_bus = tos_bus | (tb_src[k] & {DW{tb_oh[k]}});
    end
  end
endmodule

// File: rtl/ctlword_stack_core.sv
module ctlword_stack_core
  import scm_pkg::*;
#(
  parameter int DW  = 16,
  parameter int PW  = 8,
  parameter int PCW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [PCW-1:0] op_addr,
  input  logic [7:0]     op_data,
  input  logic [DW-1:0]  rom_data,
  output logic [PW-1:0]  stk_addr,
  input  logic [DW-1:0]  stk_rdata,
  output logic           stk_we,
  output logic [DW-1:0]  stk_wdata,
  output logic [DW-1:0]  ram_addr,
  input  logic [DW-1:0]  ram_rdata,
  output logic           ram_we,
  output logic [DW-1:0]  ram_wdata,
  output logic [DW-1:0]  tos,
  output logic [PW-1:0]  d_ptr,
  output logic [PW-1:0]  r_ptr
);
  localparam logic [PCW-1:0] PC_ONE = PCW'(1);

  ctl_t          ctl;
  logic [3:0]    sb_oh, tb_oh;
  logic [PCW-1:0] pc_q, pc_nx;
  logic          ph_q;
  logic [DW-1:0] tos_q, tos_drv, stk_bus, tos_bus;
  logic          jump_take;

  scm_decode u_dec (
    .op     (op_data),
    .ctl    (ctl),
    .sb_oh  (sb_oh),
    .tb_oh  (tb_oh),
    .stk_we (stk_we),
    .ram_we (ram_we)
  );

  scm_ptrs #(.PW(PW)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .use_r   (ctl.use_r),
    .step_en (ctl.step_en),
    .step_up (ctl.step_up),
    .d_ptr   (d_ptr),
    .r_ptr   (r_ptr),
    .cur     (stk_addr)
  );

  scm_datapath #(.DW(DW)) u_dp (
    .tos_q     (tos_q),
    .tos_off   (ctl.tos_off),
    .sb_oh     (sb_oh),
    .tb_oh     (tb_oh),
    .stk_rdata (stk_rdata),
    .ram_rdata (ram_rdata),
    .rom_data  (rom_data),
    .tos_drv   (tos_drv),
    .stk_bus   (stk_bus),
    .tos_bus   (tos_bus)
  );

  assign jump_take = tb_oh[TB_JZ] && (tos_q == '0);
  assign pc_nx     = jump_take ? rom_data[PCW-1:0] : pc_q + PC_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ph_q  <= 1'b0;
      tos_q <= '0;
    end else begin
      pc_q <= pc_nx;
      ph_q <= ~ph_q;
      if (ph_q)
        tos_q <= tos_bus;
    end
  end

  assign op_addr   = pc_q;
  assign stk_wdata = stk_bus;
  assign ram_wdata = stk_bus;
  assign ram_addr  = tos_drv;
  assign tos       = tos_q;

  AST_TOS_ODD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_q |=> tos_q == $past(tos_q)); // R10
  AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.tb == TB_JZ && tos_q == '0) |=> pc_q == $past(rom_data[PCW-1:0])); // R11
  AST_OPERAND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sb == SB_OPERAND) |-> (!stk_we && !ram_we)); // R5
  AST_TOS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.tos_off |-> (ram_addr == '0)); // R4
  AST_RAM_WR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sb == SB_TO_RAM) |-> (ram_we && !stk_we && ram_wdata == stk_rdata)); // R7
endmodule

// File: tb/ctlword_stack_core_test.sv
module ctlword_stack_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  op_addr, op_data, stk_addr, d_ptr, r_ptr;
  logic [15:0] rom_data, stk_rdata, stk_wdata, ram_addr, ram_rdata, ram_wdata, tos;
  logic        stk_we, ram_we;

  logic [7:0]  opmem [256];
  logic [15:0] rom [256];
  logic [15:0] smem [256];
  logic [15:0] rmem [256];
  logic [15:0] ms [256];
  logic [15:0] mr [256];

  assign op_data   = opmem[op_addr];
  assign rom_data  = rom[op_addr];
  assign stk_rdata = smem[stk_addr];
  assign ram_rdata = rmem[ram_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n && stk_we) smem[stk_addr] <= stk_wdata;
    if (rst_n && ram_we) rmem[ram_addr[7:0]] <= ram_wdata;
  end

  ctlword_stack_core uut (
    .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .op_data(op_data),
    .rom_data(rom_data), .stk_addr(stk_addr), .stk_rdata(stk_rdata),
    .stk_we(stk_we), .stk_wdata(stk_wdata), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .tos(tos), .d_ptr(d_ptr), .r_ptr(r_ptr)
  );

  typedef struct {
    logic [7:0]  op, pc, d, r, sa;
    logic        swe, rwe;
    logic [15:0] swd, ra, rwd, tos;
  } exp_t;
  exp_t sbq [$];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  logic [7:0]  m_pc, m_d, m_r;
  logic [15:0] m_tos;
  logic        m_ph;

  task automatic model_step(output exp_t e);
    logic [7:0]  op, p;
    logic [15:0] td, sr, rr, bus, tb;
    op = opmem[m_pc];
    p  = op[7] ? m_r : m_d;
    td = op[4] ? 16'h0 : m_tos;
    sr = ms[p];
    rr = mr[td[7:0]];
    case (op[3:2])
      2'd0: bus = sr;
      2'd1: bus = td;
      2'd2: bus = sr;
      default: bus = rr;
    endcase
    case (op[1:0])
      2'd0: tb = rom[m_pc];
      2'd1: tb = ~(td & bus);
      2'd2: tb = td + bus;
      default: tb = m_tos;
    endcase
    e.op = op; e.pc = m_pc; e.d = m_d; e.r = m_r; e.sa = p;
    e.swe = (op[3:2] == 2'd1) || (op[3:2] == 2'd3);
    e.rwe = (op[3:2] == 2'd2);
    e.swd = bus; e.ra = td; e.rwd = bus; e.tos = m_tos;
    if (e.swe) ms[p] = bus;
    if (e.rwe) mr[td[7:0]] = bus;
    if (op[1:0] == 2'd3 && m_tos == 16'h0) m_pc = rom[m_pc][7:0];
    else m_pc = m_pc + 8'd1;
    if (op[5]) begin
      if (op[7]) m_r = op[6] ? m_r + 8'd1 : m_r - 8'd1;
      else       m_d = op[6] ? m_d + 8'd1 : m_d - 8'd1;
    end
    if (m_ph) m_tos = tb;
    m_ph = ~m_ph;
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        string wtag;
        e = sbq.pop_front();
        wtag = (e.op[3:2] == 2'd1) ? "R6" : (e.op[3:2] == 2'd3) ? "R8" : "R5";
        chk(op_addr == e.pc, "R11 pc", {8'h0, op_addr}, {8'h0, e.pc});
        chk(stk_addr == e.sa, "R2 stk_addr", {8'h0, stk_addr}, {8'h0, e.sa});
        chk(d_ptr == e.d, "R3 d_ptr", {8'h0, d_ptr}, {8'h0, e.d});
        chk(r_ptr == e.r, "R3 r_ptr", {8'h0, r_ptr}, {8'h0, e.r});
        chk(stk_we == e.swe, wtag, {15'h0, stk_we}, {15'h0, e.swe});
        if (e.swe) chk(stk_wdata == e.swd, wtag, stk_wdata, e.swd);
        chk(ram_we == e.rwe, e.rwe ? "R7" : "R5", {15'h0, ram_we}, {15'h0, e.rwe});
        chk(ram_addr == e.ra, e.op[4] ? "R4 ram_addr" : "R7 ram_addr", ram_addr, e.ra);
        if (e.rwe) chk(ram_wdata == e.rwd, "R7 ram_wdata", ram_wdata, e.rwd);
        chk(tos == e.tos, "R9,R10 tos", tos, e.tos);
      end
    end
  end

  task automatic put(input int a, input logic [7:0] op, input logic [15:0] w);
    opmem[a] = op;
    rom[a] = w;
  endtask

  // driver
  initial begin
    for (int a = 0; a < 256; a++) begin
      opmem[a] = 8'(a * 37 + 11);
      rom[a]   = 16'(a * 1031 + 7);
      smem[a]  = 16'(a * 3 + 100);
      ms[a]    = 16'(a * 3 + 100);
      rmem[a]  = 16'(a * 5 + 9);
      mr[a]    = 16'(a * 5 + 9);
    end
    put(0, 8'h64, 16'h0000); put(1, 8'h10, 16'h1234);
    put(2, 8'h64, 16'h0000); put(3, 8'h10, 16'h00C8);
    put(4, 8'h22, 16'h0000); put(5, 8'h02, 16'h0000);
    put(6, 8'h0B, 16'h0040); put(7, 8'h0F, 16'h0040);
    put(8, 8'hE4, 16'h0000); put(9, 8'h31, 16'h0000);
    put(10, 8'h20, 16'h0000); put(11, 8'h60, 16'h0000);
    put(12, 8'hA3, 16'h0020);
    put(32, 8'hA0, 16'h0000); put(33, 8'h1A, 16'h0000);
    put(34, 8'h03, 16'h0050); put(35, 8'hE0, 16'hBEEF);
    put(36, 8'h14, 16'h0000); put(37, 8'h0D, 16'h0000);
    m_pc = 0; m_d = 0; m_r = 0; m_tos = 0; m_ph = 0;

    repeat (3) @(negedge clk);
    #1;
    chk(op_addr == 8'h0 && d_ptr == 8'h0 && r_ptr == 8'h0, "R1 reset ptrs", {op_addr, d_ptr | r_ptr}, 16'h0);
    chk(tos == 16'h0, "R1 reset tos", tos, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 600; i++) begin
      exp_t e;
      if (i == 2) begin
        #1;
        chk(tos == 16'h1234, "R12 literal in tos", tos, 16'h1234);
        chk(d_ptr == 8'd1, "R12 d advanced", {8'h0, d_ptr}, 16'd1);
        chk(smem[0] == 16'h0, "R12 old tos pushed", smem[0], 16'h0);
      end
      model_step(e);
      sbq.push_back(e);
      @(negedge clk);
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(op_addr == 8'h0 && d_ptr == 8'h0 && r_ptr == 8'h0, "R1 mid-run reset ptrs", {op_addr, d_ptr | r_ptr}, 16'h0);
    chk(tos == 16'h0, "R1 mid-run reset tos", tos, 16'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule